// File: doc/BRIEF.md
# Streaming Hamming Parity Generator for NAND Chunks

This block watches a byte stream headed to or from a NAND device and builds a single-error-correcting Hamming parity word over each fixed-size chunk (256 bytes by default). Each accepted byte adds its contribution to six column-parity bits and to a pair of line-parity bits for every bit of the byte's offset inside the chunk. When the final byte of a chunk is accepted, the block latches the finished word into a result register, pulses a done flag and restarts from zero. Each chunk therefore stands alone.

The stream port only observes a handshake that belongs to the surrounding datapath. The block never drives `s_ready`. A byte counts only in a cycle where `s_valid` and `s_ready` are both high. A stalled cycle, where valid is high and ready is low, counts for nothing, so back-pressure from the consumer needs no extra handling. Two configuration levels must both be high for bytes to count. Software pulses a clear before each page so that a partial chunk left over from an earlier transfer is discarded.

Beside the raw word, the block presents the form written to the spare area: the word shifted left by two, inverted, and truncated to 24 bits. This form is split into three bytes and given in the order they are written.

Top module: `hamming_ecc_gen`

## Requirements
- R1: A byte is accumulated only in a cycle where `s_valid`, `s_ready`, `cfg_ecc_en` and `cfg_ecc_stream` are all 1 and `ecc_clear` is 0. The byte's offset in the chunk is the number of bytes accepted since the last chunk end, clear or reset.
- R2: Word bits [5:0] hold the column parity, defined for j = 0..2. Bit 2j is the XOR of every data bit, across all bytes of the chunk, whose bit index has bit j equal to 0. Bit 2j+1 covers the data bits whose bit index has bit j equal to 1.
- R3: Word bits from 6 upward hold the line parity, defined for each offset bit k (0..ADDR_W-1). Word bit 6+2k is the XOR of the byte parities of the bytes whose offset has bit k equal to 0. Word bit 7+2k covers the bytes whose offset has bit k equal to 1.
- R4: In the clock edge that accepts the last byte of a chunk, `ecc_word` takes the finished value and `ecc_done` goes high for exactly one cycle. `ecc_word` holds that value until the next chunk ends.
- R5: After a chunk ends, the next chunk starts from zero parity and offset 0, so consecutive chunks do not affect each other.
- R6: `ecc_clear` high discards the partial parity and the offset, and it wins over a byte offered in the same cycle. It does not alter `ecc_word` and does not raise `ecc_done`.
- R7: A byte offered while `cfg_ecc_en` or `cfg_ecc_stream` is 0, or while `s_ready` is 0, has no effect on any later result.
- R8: The stored form is S = ~(ecc_word << 2) truncated to 24 bits. `spare_b0` = S[23:16] is written first, then `spare_b1` = S[15:8`, then `spare_b2` = S[7:0]. Bits [1:0] of S are therefore always 1.
- R9: After reset, `ecc_word` is 0, `ecc_done` is 0 and all three spare bytes are 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ecc_en | input | 1 | Parity generation enabled |
| cfg_ecc_stream | input | 1 | Parity taken from the streamed transfer |
| ecc_clear | input | 1 | Discard the partial chunk parity and offset |
| s_valid | input | 1 | Stream byte valid (observed) |
| s_ready | input | 1 | Stream byte ready (observed, driven by the consumer) |
| s_data | input | 8 | Stream byte |
| ecc_word | output | 2*ADDR_W+6 | Latched parity of the last finished chunk |
| ecc_done | output | 1 | One-cycle pulse when `ecc_word` is updated |
| spare_b0 | output | 8 | Stored form, first byte |
| spare_b1 | output | 8 | Stored form, second byte |
| spare_b2 | output | 8 | Stored form, third byte |

## Verification
A wrong offset count does not stay hidden. It moves the `ecc_done` pulse away from the chunk-size boundary and puts bytes into the wrong line-parity pairs, so the first finished chunk already shows a mismatched word. A stuck or mis-wired parity bit shows up in a sweep of chunks that each carry a single set bit at every offset and bit position, because each such chunk sets a distinct one-hot pattern in every pair. A leak between chunks, a byte counted during a stall, or a clear that does not win over its own cycle each corrupts the word of the next chunk, and that word can be read one cycle after the chunk's last byte.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int COL_W   = 6;
  localparam int STORE_W = 24;
  localparam int SHIFT   = 2;
endpackage

// File: rtl/ecc_col_tap.sv
module ecc_col_tap
  import nand_ecc_pkg::*;
(
  input  logic [7:0]       data,
  output logic [COL_W-1:0] col
);
  for (genvar j = 0; j < 3; j++) begin : g_pair
    logic [7:0] m_hi;
    always_comb begin
      for (int i = 0; i < 8; i++) m_hi[i] = ((i >> j) & 1) == 1;
    end
    assign col[2*j]   = ^(data & ~m_hi);
    assign col[2*j+1] = ^(data &  m_hi);
  end
endmodule

// File: rtl/ecc_line_tap.sv
module ecc_line_tap #(
  parameter int ADDR_W = 8,
  localparam int LINE_W = 2 * ADDR_W
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic              byte_par,
  output logic [LINE_W-1:0] line
);
  for (genvar k = 0; k < ADDR_W; k++) begin : g_bit
    assign line[2*k]   = byte_par & ~offset[k];
    assign line[2*k+1] = byte_par &  offset[k];
  end
endmodule

// File: rtl/ecc_chunk_ctr.sv
module ecc_chunk_ctr #(
  parameter int CHUNK_BYTES = 256,
  localparam int ADDR_W = $clog2(CHUNK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] offset,
  output logic              at_last
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(CHUNK_BYTES - 1);

  assign at_last = (offset == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      offset <= '0;
    else if (clear)  offset <= '0;
    else if (step)   offset <= at_last ? '0 : offset + 1'b1;
  end

  AST_CLEAR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> offset == '0); // R6
  AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !at_last) |=> offset == $past(offset) + 1'b1); // R1
endmodule

// File: rtl/hamming_ecc_gen.sv
module hamming_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 256,
  localparam int ADDR_W = $clog2(CHUNK_BYTES),
  localparam int LINE_W = 2 * ADDR_W,
  localparam int WORD_W = LINE_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ecc_en,
  input  logic              cfg_ecc_stream,
  input  logic              ecc_clear,
  input  logic              s_valid,
  input  logic              s_ready,
  input  logic [7:0]        s_data,
  output logic [WORD_W-1:0] ecc_word,
  output logic              ecc_done,
  output logic [7:0]        spare_b0,
  output logic [7:0]        spare_b1,
  output logic [7:0]        spare_b2
);
  logic              take, last_take, at_last;
  logic [ADDR_W-1:0] offset;
  logic [COL_W-1:0]  col_c;
  logic [LINE_W-1:0] line_c;
  logic [WORD_W-1:0] acc, acc_next;
  logic [STORE_W-1:0] stored;

  assign take      = s_valid & s_ready & cfg_ecc_en & cfg_ecc_stream & ~ecc_clear;
  assign last_take = take & at_last;

  ecc_chunk_ctr #(.CHUNK_BYTES(CHUNK_BYTES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear(ecc_clear), .step(take),
    .offset(offset), .at_last(at_last)
  );

  ecc_col_tap u_col (.data(s_data), .col(col_c));

  ecc_line_tap #(.ADDR_W(ADDR_W)) u_line (
    .offset(offset), .byte_par(^s_data), .line(line_c)
  );

  assign acc_next = acc ^ {line_c, col_c};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      ecc_word <= '0;
      ecc_done <= 1'b0;
    end else begin
      ecc_done <= last_take;
      if (ecc_clear) begin
        acc <= '0;
      end else if (take) begin
        if (at_last) begin
          acc      <= '0;
          ecc_word <= acc_next;
        end else begin
          acc <= acc_next;
        end
      end
    end
  end

  assign stored   = ~(STORE_W'(ecc_word) << SHIFT);
  assign spare_b0 = stored[23:16];
  assign spare_b1 = stored[15:8];
  assign spare_b2 = stored[7:0];

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_done |=> !ecc_done); // R4
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !last_take |=> $stable(ecc_word)); // R4
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_done |-> acc == '0); // R5
  AST_IGNORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !ecc_clear) |=> $stable(acc)); // R7
  AST_CLEAR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_clear |=> !ecc_done); // R6
  AST_STORE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    spare_b2[1:0] == 2'b11); // R8
endmodule

// File: tb/sim_hamming_ecc_gen.sv
`timescale 1ns/1ps
module sim_hamming_ecc_gen;
  localparam int CH = 16;
  localparam int AW = 4;
  localparam int WW = 2 * AW + 6;

  logic clk = 0, rst_n = 0;
  logic cfg_ecc_en = 0, cfg_ecc_stream = 0, ecc_clear = 0;
  logic s_valid = 0, s_ready = 0;
  logic [7:0] s_data = 0;
  logic [WW-1:0] ecc_word;
  logic ecc_done;
  logic [7:0] spare_b0, spare_b1, spare_b2;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] chunk_q [CH];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  hamming_ecc_gen #(.CHUNK_BYTES(CH)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_ecc_en(cfg_ecc_en), .cfg_ecc_stream(cfg_ecc_stream),
    .ecc_clear(ecc_clear), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .ecc_word(ecc_word), .ecc_done(ecc_done),
    .spare_b0(spare_b0), .spare_b1(spare_b1), .spare_b2(spare_b2)
  );

  function automatic logic [WW-1:0] model();
    logic [WW-1:0] w = '0;
    for (int a = 0; a < CH; a++) begin
      for (int b = 0; b < 8; b++) begin
        if (chunk_q[a][b]) begin
          for (int j = 0; j < 3; j++) w[2*j + ((b >> j) & 1)] ^= 1'b1;
          for (int k = 0; k < AW; k++) w[6 + 2*k + ((a >> k) & 1)] ^= 1'b1;
        end
      end
    end
    return w;
  endfunction

  function automatic logic [23:0] store_of(input logic [WW-1:0] w);
    logic [23:0] v;
    v = 24'(w) * 4;
    return 24'hFFFFFF - v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic r, input logic [7:0] d, input logic clr);
    @(negedge clk);
    s_valid = v; s_ready = r; s_data = d; ecc_clear = clr;
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic send_chunk(input bit stalls);
    for (int i = 0; i < CH; i++) begin
      if (stalls) begin
        step_lfsr();
        if (lfsr[0]) cyc(1, 0, 8'hA5, 0);
        if (lfsr[1]) cyc(0, 1, 8'h3C, 0);
      end
      cyc(1, 1, chunk_q[i], 0);
    end
  endtask

  task automatic check_result(input string tag);
    logic [WW-1:0] e;
    logic [23:0] s;
    e = model();
    s = store_of(e);
    cyc(0, 0, 8'h00, 0);
    chk(ecc_done === 1'b1, {tag, " R4 done"}, 32'(ecc_done), 1);
    chk(ecc_word === e, {tag, " R2 R3 word"}, 32'(ecc_word), 32'(e));
    chk({spare_b0, spare_b1, spare_b2} === s, {tag, " R8 stored"},
        32'({spare_b0, spare_b1, spare_b2}), 32'(s));
    cyc(0, 0, 8'h00, 0);
    chk(ecc_done === 1'b0 && ecc_word === e, {tag, " R4 hold"}, 32'(ecc_word), 32'(e));
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] held;
    repeat (3) @(negedge clk);
    chk(ecc_word === '0 && ecc_done === 1'b0, "R9 reset word", 32'(ecc_word), 0);
    chk({spare_b0, spare_b1, spare_b2} === 24'hFFFFFF, "R9 reset stored",
        32'({spare_b0, spare_b1, spare_b2}), 32'hFFFFFF);
    rst_n = 1;
    cfg_ecc_en = 1; cfg_ecc_stream = 1;

    // R2 R3 R5: single-bit sweep over every offset and bit position
    for (int a = 0; a < CH; a++) begin
      for (int b = 0; b < 8; b++) begin
        for (int i = 0; i < CH; i++) chunk_q[i] = 8'h00;
        chunk_q[a][b] = 1'b1;
        send_chunk(0);
        check_result("sweep");
      end
    end

    // R1 R5: random chunks, back to back, with stalls
    for (int n = 0; n < 24; n++) begin
      for (int i = 0; i < CH; i++) begin step_lfsr(); chunk_q[i] = lfsr[7:0] ^ lfsr[15:8]; end
      send_chunk(n[0]);
      check_result("random R1");
    end

    // All-ones chunk
    for (int i = 0; i < CH; i++) chunk_q[i] = 8'hFF;
    send_chunk(1);
    check_result("ones");

    // R7: bytes ignored while either enable is low
    held = ecc_word;
    cfg_ecc_en = 0;
    for (int i = 0; i < 5; i++) cyc(1, 1, 8'h81, 0);
    cfg_ecc_en = 1; cfg_ecc_stream = 0;
    for (int i = 0; i < CH + 3; i++) cyc(1, 1, 8'h42, 0);
    cyc(0, 0, 0, 0);
    chk(ecc_done === 1'b0 && ecc_word === held, "R7 disabled no effect", 32'(ecc_word), 32'(held));
    cfg_ecc_stream = 1;
    for (int i = 0; i < CH; i++) chunk_q[i] = 8'(i * 37 + 5);
    send_chunk(0);
    check_result("after disabled R7");

    // R6: clear discards partial chunk and wins over its own byte
    held = ecc_word;
    for (int i = 0; i < 7; i++) cyc(1, 1, 8'hE7, 0);
    cyc(1, 1, 8'h99, 1);
    cyc(0, 0, 0, 0);
    chk(ecc_done === 1'b0 && ecc_word === held, "R6 clear keeps word", 32'(ecc_word), 32'(held));
    for (int i = 0; i < CH; i++) chunk_q[i] = 8'(8'h10 + i);
    send_chunk(0);
    check_result("after clear R6");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule